// File: doc/BRIEF.md
# Passive Serial Configuration Shifter

This block loads a bitstream into a target programmable device over a one-bit serial configuration link. A start command holds the target's configuration-reset line low for a timed window, then releases it and waits for the target to raise its status line. After that, bytes arrive on a valid/ready stream. Each byte goes out on a single data line, one bit per clock pulse, with the least-significant bit first.

Once the last byte has been shifted, a finish command samples the target's status and done lines. The block then reports one of three outcomes: success, failure, or incomplete. If the target never becomes ready within a bounded wait, the block reports a separate timeout outcome and does not hang. The timing parameters count system clocks: the reset window, the readiness timeout, and the high and low phases of the serial clock.

Top module: `ps_cfg_shifter`

## Requirements
- R1: A `startReq` pulse seen in idle drives `cfgNConfig` low for exactly RESET_CYCLES clocks, with `cfgDclk` and `cfgData0` also low. After that window `cfgNConfig` goes high again. A `startReq` outside idle is ignored.
- R2: After the reset window the block waits for `tgtNStatus` high. `inReady` stays low until `tgtNStatus` is seen high, and it rises on the following cycle.
- R3: If `tgtNStatus` stays low for READY_TIMEOUT clocks of waiting, `resultValid` pulses with `resultCode` 0 (timeout) and the block returns to idle.
- R4: An accepted byte is sent least-significant bit first as 8 bits. For each bit, `cfgData0` carries the bit for LOW_CYCLES clocks with `cfgDclk` low, then for HIGH_CYCLES clocks with `cfgDclk` high. `cfgData0` does not change while `cfgDclk` is high.
- R5: `cfgDclk` and `cfgData0` are low whenever no bit is being shifted. `cfgNConfig` is high at all times except during the reset window, including the whole of the transfer.
- R6: `inReady` is high only in the loading state, and only while no bit is being shifted and `finishReq` is low. A byte is taken only on a cycle with both `inValid` and `inReady` high.
- R7: A `finishReq` pulse in the loading state with `tgtNStatus` low reports `resultCode` 2 (failure).
- R8: A `finishReq` pulse in the loading state with `tgtNStatus` high and `tgtConfDone` high reports `resultCode` 1 (success).
- R9: A `finishReq` pulse in the loading state with `tgtNStatus` high and `tgtConfDone` low reports `resultCode` 3 (incomplete).
- R10: `resultValid` is high for exactly one clock, the clock after the deciding cycle, and the block is then idle. A `finishReq` outside the loading state is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Begin a configuration sequence (taken in idle) |
| finishReq | input | 1 | End the load and classify target status (taken while loading) |
| inData | input | BYTE_W | Bitstream byte |
| inValid | input | 1 | `inData` holds a byte |
| inReady | output | 1 | Block can take a byte this cycle |
| tgtNStatus | input | 1 | Target status line, high when healthy |
| tgtConfDone | input | 1 | Target configuration-done line |
| cfgNConfig | output | 1 | Active-low configuration reset to the target |
| cfgDclk | output | 1 | Serial configuration clock to the target |
| cfgData0 | output | 1 | Serial configuration data to the target |
| resultValid | output | 1 | One-cycle pulse carrying an outcome |
| resultCode | output | 2 | 0 timeout, 1 success, 2 failure, 3 incomplete |

## Verification
The bench builds the block with a 4-clock reset window, a 6-clock readiness timeout, a 3-clock low phase and a 2-clock high phase. With these short windows the timeout path can be reached within a few cycles. The unequal phases also expose any swap of the high and low counts or any off-by-one in them. In parallel with the clock-by-clock comparison, the bench rebuilds each byte from `cfgData0` at every rising edge of `cfgDclk`, which checks the bit order on its own.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

  typedef enum logic [1:0] {
    RES_TIMEOUT = 2'd0,
    RES_OK      = 2'd1,
    RES_FAIL    = 2'd2,
    RES_PARTIAL = 2'd3
  } resultCode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic        loadByte;
    logic        shiftBit;
    logic        setResult;
    resultCode_e code;
  } dpStrobe_t;

endpackage

// File: rtl/ps_cfg_ctrl.sv
module ps_cfg_ctrl
  import ps_cfg_pkg::*;
#(
  parameter int RESET_CYCLES  = 2000,
  parameter int READY_TIMEOUT = 4096,
  parameter int HIGH_CYCLES   = 1,
  parameter int LOW_CYCLES    = 1,
  parameter int BYTE_W        = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      startReq,
  input  logic      finishReq,
  input  logic      inValid,
  input  logic      tgtNStatus,
  input  logic      tgtConfDone,
  output logic      inReady,
  output logic      cfgNConfig,
  output logic      cfgDclk,
  output logic      shifting,
  output dpStrobe_t strobe
);

  localparam int MAX_A   = (RESET_CYCLES > READY_TIMEOUT) ? RESET_CYCLES : READY_TIMEOUT;
  localparam int MAX_B   = (HIGH_CYCLES > LOW_CYCLES) ? HIGH_CYCLES : LOW_CYCLES;
  localparam int CNT_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int BIT_W   = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

  localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(RESET_CYCLES - 1);
  localparam logic [CNT_W-1:0] WAIT_LAST  = CNT_W'(READY_TIMEOUT - 1);
  localparam logic [CNT_W-1:0] HIGH_LAST  = CNT_W'(HIGH_CYCLES - 1);
  localparam logic [CNT_W-1:0] LOW_LAST   = CNT_W'(LOW_CYCLES - 1);
  localparam logic [BIT_W-1:0] BIT_LAST   = BIT_W'(BYTE_W - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_PULSE, ST_WAIT, ST_LOAD, ST_SHIFT
  } state_e;

  state_e           state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             phaseHi, phaseNext;
  logic [BIT_W-1:0] bitIdx, bitNext;

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    phaseNext = phaseHi;
    bitNext   = bitIdx;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          stateNext = ST_PULSE;
          cntNext   = '0;
        end
      end
      ST_PULSE: begin
        if (cnt == PULSE_LAST) begin
          stateNext = ST_WAIT;
          cntNext   = '0;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      ST_WAIT: begin
        if (tgtNStatus) begin
          stateNext = ST_LOAD;
          cntNext   = '0;
        end else if (cnt == WAIT_LAST) begin
          stateNext        = ST_IDLE;
          strobe.setResult = 1'b1;
          strobe.code      = RES_TIMEOUT;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      ST_LOAD: begin
        if (finishReq) begin
          stateNext        = ST_IDLE;
          strobe.setResult = 1'b1;
          if (!tgtNStatus)      strobe.code = RES_FAIL;
          else if (tgtConfDone) strobe.code = RES_OK;
          else                  strobe.code = RES_PARTIAL;
        end else if (inValid) begin
          strobe.loadByte = 1'b1;
          stateNext       = ST_SHIFT;
          cntNext         = '0;
          phaseNext       = 1'b0;
          bitNext         = '0;
        end
      end
      ST_SHIFT: begin
        if (!phaseHi) begin
          if (cnt == LOW_LAST) begin
            phaseNext = 1'b1;
            cntNext   = '0;
          end else begin
            cntNext = cnt + 1'b1;
          end
        end else if (cnt == HIGH_LAST) begin
          cntNext         = '0;
          phaseNext       = 1'b0;
          strobe.shiftBit = 1'b1;
          if (bitIdx == BIT_LAST) stateNext = ST_LOAD;
          else                    bitNext   = bitIdx + 1'b1;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      phaseHi <= 1'b0;
      bitIdx  <= '0;
    end else begin
      state   <= stateNext;
      cnt     <= cntNext;
      phaseHi <= phaseNext;
      bitIdx  <= bitNext;
    end
  end

  assign inReady    = (state == ST_LOAD) && !finishReq;
  assign cfgNConfig = (state != ST_PULSE);
  assign shifting   = (state == ST_SHIFT);
  assign cfgDclk    = shifting && phaseHi;

endmodule

// File: rtl/ps_cfg_datapath.sv
module ps_cfg_datapath
  import ps_cfg_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         strobe,
  input  logic [BYTE_W-1:0] inData,
  input  logic              shifting,
  output logic              cfgData0,
  output logic              resultValid,
  output logic [1:0]        resultCode
);

  logic [BYTE_W-1:0] shiftReg;
  resultCode_e       codeReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg    <= '0;
      resultValid <= 1'b0;
      codeReg     <= RES_TIMEOUT;
    end else begin
      if (strobe.loadByte)      shiftReg <= inData;
      else if (strobe.shiftBit) shiftReg <= shiftReg >> 1;
      resultValid <= strobe.setResult;
      if (strobe.setResult) codeReg <= strobe.code;
    end
  end

  assign cfgData0   = shifting & shiftReg[0];
  assign resultCode = codeReg;

endmodule

// File: rtl/ps_cfg_shifter.sv
module ps_cfg_shifter
  import ps_cfg_pkg::*;
#(
  parameter int RESET_CYCLES  = 2000,
  parameter int READY_TIMEOUT = 4096,
  parameter int HIGH_CYCLES   = 1,
  parameter int LOW_CYCLES    = 1,
  parameter int BYTE_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startReq,
  input  logic              finishReq,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  input  logic              tgtNStatus,
  input  logic              tgtConfDone,
  output logic              cfgNConfig,
  output logic              cfgDclk,
  output logic              cfgData0,
  output logic              resultValid,
  output logic [1:0]        resultCode
);

  dpStrobe_t strobe;
  logic      shifting;

  ps_cfg_ctrl #(
    .RESET_CYCLES (RESET_CYCLES),
    .READY_TIMEOUT(READY_TIMEOUT),
    .HIGH_CYCLES  (HIGH_CYCLES),
    .LOW_CYCLES   (LOW_CYCLES),
    .BYTE_W       (BYTE_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .startReq   (startReq),
    .finishReq  (finishReq),
    .inValid    (inValid),
    .tgtNStatus (tgtNStatus),
    .tgtConfDone(tgtConfDone),
    .inReady    (inReady),
    .cfgNConfig (cfgNConfig),
    .cfgDclk    (cfgDclk),
    .shifting   (shifting),
    .strobe     (strobe)
  );

  ps_cfg_datapath #(
    .BYTE_W(BYTE_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .inData     (inData),
    .shifting   (shifting),
    .cfgData0   (cfgData0),
    .resultValid(resultValid),
    .resultCode (resultCode)
  );

endmodule

// File: rtl/ps_cfg_shifter_chk.sv
module ps_cfg_shifter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       inValid,
  input logic       inReady,
  input logic       tgtNStatus,
  input logic       tgtConfDone,
  input logic       cfgNConfig,
  input logic       cfgDclk,
  input logic       cfgData0,
  input logic       resultValid,
  input logic [1:0] resultCode
);

  // R1: during the reset window the clock and data lines are quiet
  p_pulse_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgNConfig |-> (!cfgDclk && !cfgData0));

  // R4: data is held while the serial clock stays high
  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgDclk && $past(cfgDclk)) |-> $stable(cfgData0));

  // R6: a taken byte starts shifting, so ready drops
  p_accept_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady) |=> !inReady);

  // R6: never ready while the serial clock is high
  p_ready_idle_clk_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inReady |-> !cfgDclk);

  // R7: failure reported only after status was low
  p_fail_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (resultValid && resultCode == 2'd2) |-> $past(!tgtNStatus));

  // R8: success reported only after done was high
  p_ok_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (resultValid && resultCode == 2'd1) |-> $past(tgtConfDone && tgtNStatus));

  // R9: incomplete reported only after done was low
  p_partial_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (resultValid && resultCode == 2'd3) |-> $past(!tgtConfDone && tgtNStatus));

  // R10: result strobe is a single cycle
  p_result_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |=> !resultValid);

endmodule

bind ps_cfg_shifter ps_cfg_shifter_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .inValid    (inValid),
  .inReady    (inReady),
  .tgtNStatus (tgtNStatus),
  .tgtConfDone(tgtConfDone),
  .cfgNConfig (cfgNConfig),
  .cfgDclk    (cfgDclk),
  .cfgData0   (cfgData0),
  .resultValid(resultValid),
  .resultCode (resultCode)
);

// File: tb/ps_cfg_shifter_tb.sv
module ps_cfg_shifter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int RST_CYC    = 4;
  localparam int TMO_CYC    = 6;
  localparam int HI_CYC     = 2;
  localparam int LO_CYC     = 3;
  localparam int WATCHDOG   = 20000;

  localparam int M_IDLE = 0, M_PULSE = 1, M_WAIT = 2, M_LOAD = 3, M_SHIFT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       startReq = 1'b0, finishReq = 1'b0, inValid = 1'b0;
  logic [7:0] inData = 8'h00;
  logic       tgtNStatus = 1'b1, tgtConfDone = 1'b0;
  logic       inReady, cfgNConfig, cfgDclk, cfgData0, resultValid;
  logic [1:0] resultCode;

  always #(CLK_PERIOD/2) clk = ~clk;

  ps_cfg_shifter #(
    .RESET_CYCLES (RST_CYC),
    .READY_TIMEOUT(TMO_CYC),
    .HIGH_CYCLES  (HI_CYC),
    .LOW_CYCLES   (LO_CYC),
    .BYTE_W       (8)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .finishReq(finishReq),
    .inData(inData), .inValid(inValid), .inReady(inReady),
    .tgtNStatus(tgtNStatus), .tgtConfDone(tgtConfDone),
    .cfgNConfig(cfgNConfig), .cfgDclk(cfgDclk), .cfgData0(cfgData0),
    .resultValid(resultValid), .resultCode(resultCode)
  );

  int checks = 0, bad = 0, cyc = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  // behavioural reference model
  int       mMode = M_IDLE;
  int       mLeft = 0, mWait = 0;
  bit [1:0] expQ[$];
  bit [7:0] sentQ[$];
  bit       eResV = 0;
  int       eResC = 0;
  int       tally[4] = '{0, 0, 0, 0};

  always @(posedge clk) begin
    cyc++;
    eResV = 0;
    if (!rst_n) begin
      mMode = M_IDLE;
      expQ.delete();
      eResC = 0;
    end else begin
      case (mMode)
        M_IDLE:  if (startReq) begin mMode = M_PULSE; mLeft = RST_CYC; end
        M_PULSE: begin
          mLeft--;
          if (mLeft == 0) begin mMode = M_WAIT; mWait = 0; end
        end
        M_WAIT: begin
          if (tgtNStatus) mMode = M_LOAD;
          else begin
            mWait++;
            if (mWait == TMO_CYC) begin mMode = M_IDLE; eResV = 1; eResC = 0; end
          end
        end
        M_LOAD: begin
          if (finishReq) begin
            mMode = M_IDLE; eResV = 1;
            eResC = !tgtNStatus ? 2 : (tgtConfDone ? 1 : 3);
          end else if (inValid) begin
            for (int i = 0; i < 8; i++) begin
              for (int k = 0; k < LO_CYC; k++) expQ.push_back({1'b0, inData[i]});
              for (int k = 0; k < HI_CYC; k++) expQ.push_back({1'b1, inData[i]});
            end
            sentQ.push_back(inData);
            mMode = M_SHIFT;
          end
        end
        default: begin
          void'(expQ.pop_front());
          if (expQ.size() == 0) mMode = M_LOAD;
        end
      endcase
    end
  end

  // compare every clock, away from the active edge
  bit       prevDclk = 0;
  bit [7:0] rebuilt = 0;
  int       nBits = 0;

  always @(negedge clk) begin
    int eDclk, eData;
    eDclk = (mMode == M_SHIFT) ? expQ[0][1] : 0;
    eData = (mMode == M_SHIFT) ? expQ[0][0] : 0;
    chk("R1/R5 cfgNConfig", cfgNConfig, (mMode != M_PULSE));
    chk("R4/R5 cfgDclk", cfgDclk, eDclk);
    chk("R4/R5 cfgData0", cfgData0, eData);
    chk("R2/R6 inReady", inReady, (mMode == M_LOAD) && !finishReq);
    chk("R10 resultValid", resultValid, eResV);
    if (eResV) begin
      chk("R3/R7/R8/R9 resultCode", resultCode, eResC);
      tally[eResC]++;
    end
    // independent bit-order check: rebuild bytes at rising serial clock
    if (rst_n && cfgDclk && !prevDclk) begin
      rebuilt[nBits] = cfgData0;
      nBits++;
      if (nBits == 8) begin
        chk("R4 rebuilt byte", rebuilt, (sentQ.size() > 0) ? sentQ[0] : -1);
        if (sentQ.size() > 0) void'(sentQ.pop_front());
        nBits = 0;
      end
    end
    prevDclk = cfgDclk;
    if (cyc > WATCHDOG) begin
      chk("watchdog", 1, 0);
      finishRun();
    end
  end

  task automatic pulse(ref logic sig);
    @(negedge clk); #1 sig = 1'b1;
    @(negedge clk); #1 sig = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk); #1;
    inValid = 1'b1; inData = b;
    #1;
    while (!inReady) begin @(negedge clk); #2; end
    @(negedge clk); #1 inValid = 1'b0;
  endtask

  task automatic waitLoad();
    do @(negedge clk); while (mMode != M_LOAD);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R10: finish in idle ignored; R6: valid in idle not taken
    pulse(finishReq);
    @(negedge clk); #1 inValid = 1'b1; inData = 8'h5A;
    repeat (3) @(negedge clk);
    #1 inValid = 1'b0;

    // R3: target never ready
    tgtNStatus = 1'b0;
    pulse(startReq);
    repeat (RST_CYC + TMO_CYC + 4) @(negedge clk);

    // R2/R4/R8: normal load, ignored commands while shifting (R1, R10)
    pulse(startReq);
    repeat (RST_CYC + 2) @(negedge clk);
    #1 tgtNStatus = 1'b1;
    sendByte(8'hA5);
    sendByte(8'h01);
    sendByte(8'h80);
    pulse(startReq);
    pulse(finishReq);
    sendByte(8'h3C);
    waitLoad();
    #1 tgtConfDone = 1'b1;
    pulse(finishReq);
    repeat (3) @(negedge clk);

    // R7: status drops before finish
    #1 tgtConfDone = 1'b0; tgtNStatus = 1'b0;
    pulse(startReq);
    repeat (RST_CYC + 1) @(negedge clk);
    #1 tgtNStatus = 1'b1;
    sendByte(8'hFF);
    waitLoad();
    #1 tgtNStatus = 1'b0;
    pulse(finishReq);
    repeat (3) @(negedge clk);

    // R9: target ready at once, done never rises
    #1 tgtNStatus = 1'b1;
    pulse(startReq);
    sendByte(8'h00);
    waitLoad();
    pulse(finishReq);
    repeat (4) @(negedge clk);

    chk("R3 timeout results", tally[0], 1);
    chk("R8 success results", tally[1], 1);
    chk("R7 failure results", tally[2], 1);
    chk("R9 incomplete results", tally[3], 1);
    chk("R4 bytes all seen", sentQ.size(), 0);
    finishRun();
  end

endmodule